// File: doc/BRIEF.md
# Proximity Measurement Cycle Sequencer

This block sequences the repeating measurement cycle of a reflective optical proximity sensor and manages its power states. From sleep it moves to a start state once the power-on control is set, and from there runs, per cycle, a fixed settling step, a burst of LED drive pulses, an ADC integration window and an optional wait period, then returns to start. Clearing the power-on control never cuts a conversion short: the running conversion completes and its result is latched before the block drops to sleep.

All durations are counted on a single base-tick enable input. One step (nominally 2.72 ms) is `STEP_TICKS` ticks and one LED pulse period is `PULSE_TICKS` ticks, with the LED on for the first half of each period. The integration and wait registers hold two's-complement step counts (256 minus the register value). A wait-long control stretches every wait step twelvefold. The analog front end is represented by the `adc_in` word, which is captured into the result register at the end of each integration window.

Top module: `prox_cycle_seq`

## Requirements
- R1: After reset the block is in sleep with `led_o`, `integ_win_o` and `latch_o` low and `prox_data_o` zero; `state_o` encodes sleep=0, start=1, settle=2, LED accumulate=3, convert=4, wait=5.
- R2: From sleep, a set `pwr_on` moves the block to start; start lasts one clock when a phase is enabled, and holds while both `prox_en` and `wait_en` are clear.
- R3: With `prox_en` set, each cycle passes through settle for exactly `STEP_TICKS` ticks before the accumulate or convert phase, whether or not wait is enabled.
- R4: The accumulate phase lasts `pulse_cnt`×`PULSE_TICKS` ticks and shows exactly `pulse_cnt` LED pulses; `led_o` is low in every other state, and a `pulse_cnt` of 0 skips accumulate and goes from settle straight to convert.
- R5: The convert phase lasts (256−`integ_time`)×`STEP_TICKS` ticks, so 0xFF gives one step and 0x00 gives 256 steps, and `integ_win_o` is high exactly while the state is convert.
- R6: At the end of every convert phase `latch_o` pulses high for one clock, in the first clock of the following state, with `prox_data_o` holding the `adc_in` value of the final convert clock; `prox_data_o` changes at no other time.
- R7: With `wait_en` set, wait follows convert (or start when `prox_en` is clear) and lasts (256−`wait_time`)×`STEP_TICKS` ticks, twelve times that when `wait_long` is set; with `wait_en` clear the wait state is never entered.
- R8: Clearing `pwr_on` during settle, accumulate or convert lets the cycle run to the end of convert, including the latch, after which the block enters sleep without a wait phase.
- R9: Clearing `pwr_on` while in start or wait moves the block to sleep at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base time-tick enable, one clock wide |
| pwr_on | input | 1 | Power-on control |
| prox_en | input | 1 | Enables the settle, accumulate and convert phases |
| wait_en | input | 1 | Enables the wait phase |
| wait_long | input | 1 | Stretches each wait step by twelve |
| pulse_cnt | input | 8 | Number of LED pulses per cycle |
| integ_time | input | 8 | Integration time, 256 minus step count |
| wait_time | input | 8 | Wait time, 256 minus step count |
| adc_in | input | DATA_W | Conversion result from the front-end model |
| led_o | output | 1 | LED drive strobe |
| integ_win_o | output | 1 | Integrate/convert window |
| state_o | output | 3 | Current state code |
| latch_o | output | 1 | One-clock result-latch strobe |
| prox_data_o | output | DATA_W | Latched proximity result |

## Verification
The assertions assume the enable controls do not change in the one clock the block spends in start, and that configuration registers are held steady across a measurement cycle; the bench changes configuration only while the block sleeps and moves `pwr_on` only at a chosen phase entry. The tick input is assumed to be a plain enable with no relation to the clock phase, so the bench runs the same scoreboard with a tick every clock and with a tick every third clock. Durations are compared in counted ticks per state visit, which keeps every expected value independent of where a state is entered relative to the tick pattern.

// File: rtl/prox_seq_pkg.sv
`timescale 1ns/1ps
package prox_seq_pkg;

    localparam int CFG_W      = 8;
    localparam int STEP_CNT_W = 12;
    localparam int LONG_MULT  = 12;

    typedef enum logic [2:0] {
        PS_SLEEP   = 3'd0,
        PS_START   = 3'd1,
        PS_SETTLE  = 3'd2,
        PS_ACCUM   = 3'd3,
        PS_CONVERT = 3'd4,
        PS_WAIT    = 3'd5
    } prox_state_e;

    typedef struct packed {
        logic                  load;
        logic [STEP_CNT_W-1:0] steps;
    } step_cmd_t;

    typedef struct packed {
        logic             load;
        logic [CFG_W-1:0] count;
    } pulse_cmd_t;

    function automatic logic [STEP_CNT_W-1:0] integ_steps(input logic [CFG_W-1:0] reg_val);
        return STEP_CNT_W'(9'd256 - {1'b0, reg_val});
    endfunction

    function automatic logic [STEP_CNT_W-1:0] wait_steps(input logic [CFG_W-1:0] reg_val,
                                                         input logic              stretch);
        logic [STEP_CNT_W-1:0] base;
        base = STEP_CNT_W'(9'd256 - {1'b0, reg_val});
        return stretch ? STEP_CNT_W'(base * STEP_CNT_W'(LONG_MULT)) : base;
    endfunction

endpackage

// File: rtl/prox_step_timer.sv
`timescale 1ns/1ps
module prox_step_timer
    import prox_seq_pkg::*;
#(
    parameter int STEP_TICKS = 340
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  step_cmd_t cmd,
    output logic      done
);
    localparam int TW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(STEP_TICKS - 1);

    logic [TW-1:0]         tick_cnt;
    logic [STEP_CNT_W-1:0] steps_left;
    logic                  running;

    assign done = running && tick && (tick_cnt == LAST_TICK)
                  && (steps_left == STEP_CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt   <= '0;
            steps_left <= '0;
            running    <= 1'b0;
        end else if (cmd.load) begin
            tick_cnt   <= '0;
            steps_left <= cmd.steps;
            running    <= 1'b1;
        end else if (running && tick) begin
            if (tick_cnt == LAST_TICK) begin
                tick_cnt <= '0;
                if (steps_left == STEP_CNT_W'(1)) begin
                    running <= 1'b0;
                end else begin
                    steps_left <= steps_left - STEP_CNT_W'(1);
                end
            end else begin
                tick_cnt <= tick_cnt + TW'(1);
            end
        end
    end
endmodule

// File: rtl/prox_pulse_gen.sv
`timescale 1ns/1ps
module prox_pulse_gen
    import prox_seq_pkg::*;
#(
    parameter int PULSE_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  pulse_cmd_t cmd,
    output logic       led,
    output logic       done
);
    localparam int PW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [PW-1:0] LAST_PH = PW'(PULSE_TICKS - 1);
    localparam logic [PW-1:0] HALF_PH = PW'(PULSE_TICKS / 2);

    logic [PW-1:0]    phase;
    logic [CFG_W-1:0] pulses_left;
    logic             running;

    assign led  = running && (phase < HALF_PH);
    assign done = running && tick && (phase == LAST_PH)
                  && (pulses_left == CFG_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= '0;
            pulses_left <= '0;
            running     <= 1'b0;
        end else if (cmd.load) begin
            phase       <= '0;
            pulses_left <= cmd.count;
            running     <= (cmd.count != '0);
        end else if (running && tick) begin
            if (phase == LAST_PH) begin
                phase <= '0;
                if (pulses_left == CFG_W'(1)) begin
                    running <= 1'b0;
                end else begin
                    pulses_left <= pulses_left - CFG_W'(1);
                end
            end else begin
                phase <= phase + PW'(1);
            end
        end
    end
endmodule

// File: rtl/prox_seq_fsm.sv
`timescale 1ns/1ps
module prox_seq_fsm
    import prox_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_on,
    input  logic             prox_en,
    input  logic             wait_en,
    input  logic             wait_long,
    input  logic [CFG_W-1:0] pulse_cnt,
    input  logic [CFG_W-1:0] integ_time,
    input  logic [CFG_W-1:0] wait_time,
    input  logic             step_done,
    input  logic             pulse_done,
    output prox_state_e      state,
    output step_cmd_t        step_cmd,
    output pulse_cmd_t       pulse_cmd,
    output logic             conv_end
);
    prox_state_e state_q, state_d;

    always_comb begin
        state_d         = state_q;
        step_cmd.load   = 1'b0;
        step_cmd.steps  = '0;
        pulse_cmd.load  = 1'b0;
        pulse_cmd.count = pulse_cnt;
        conv_end        = 1'b0;
        case (state_q)
            PS_SLEEP: begin
                if (pwr_on) state_d = PS_START;
            end
            PS_START: begin
                if (!pwr_on) begin
                    state_d = PS_SLEEP;
                end else if (prox_en) begin
                    state_d        = PS_SETTLE;
                    step_cmd.load  = 1'b1;
                    step_cmd.steps = STEP_CNT_W'(1);
                end else if (wait_en) begin
                    state_d        = PS_WAIT;
                    step_cmd.load  = 1'b1;
                    step_cmd.steps = wait_steps(wait_time, wait_long);
                end
            end
            PS_SETTLE: begin
                if (step_done) begin
                    if (pulse_cnt != '0) begin
                        state_d        = PS_ACCUM;
                        pulse_cmd.load = 1'b1;
                    end else begin
                        state_d        = PS_CONVERT;
                        step_cmd.load  = 1'b1;
                        step_cmd.steps = integ_steps(integ_time);
                    end
                end
            end
            PS_ACCUM: begin
                if (pulse_done) begin
                    state_d        = PS_CONVERT;
                    step_cmd.load  = 1'b1;
                    step_cmd.steps = integ_steps(integ_time);
                end
            end
            PS_CONVERT: begin
                if (step_done) begin
                    conv_end = 1'b1;
                    if (!pwr_on) begin
                        state_d = PS_SLEEP;
                    end else if (wait_en) begin
                        state_d        = PS_WAIT;
                        step_cmd.load  = 1'b1;
                        step_cmd.steps = wait_steps(wait_time, wait_long);
                    end else begin
                        state_d = PS_START;
                    end
                end
            end
            PS_WAIT: begin
                if (!pwr_on) begin
                    state_d = PS_SLEEP;
                end else if (step_done) begin
                    state_d = PS_START;
                end
            end
            default: state_d = PS_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_SLEEP;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/prox_cycle_seq.sv
`timescale 1ns/1ps
module prox_cycle_seq
    import prox_seq_pkg::*;
#(
    parameter int STEP_TICKS  = 340,
    parameter int PULSE_TICKS = 2,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pwr_on,
    input  logic              prox_en,
    input  logic              wait_en,
    input  logic              wait_long,
    input  logic [7:0]        pulse_cnt,
    input  logic [7:0]        integ_time,
    input  logic [7:0]        wait_time,
    input  logic [DATA_W-1:0] adc_in,
    output logic              led_o,
    output logic              integ_win_o,
    output logic [2:0]        state_o,
    output logic              latch_o,
    output logic [DATA_W-1:0] prox_data_o
);
    prox_state_e state;
    step_cmd_t   step_cmd;
    pulse_cmd_t  pulse_cmd;
    logic        step_done;
    logic        pulse_done;
    logic        conv_end;

    prox_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwr_on     (pwr_on),
        .prox_en    (prox_en),
        .wait_en    (wait_en),
        .wait_long  (wait_long),
        .pulse_cnt  (pulse_cnt),
        .integ_time (integ_time),
        .wait_time  (wait_time),
        .step_done  (step_done),
        .pulse_done (pulse_done),
        .state      (state),
        .step_cmd   (step_cmd),
        .pulse_cmd  (pulse_cmd),
        .conv_end   (conv_end)
    );

    prox_step_timer #(.STEP_TICKS(STEP_TICKS)) u_step (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cmd  (step_cmd),
        .done (step_done)
    );

    prox_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cmd  (pulse_cmd),
        .led  (led_o),
        .done (pulse_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_o     <= 1'b0;
            prox_data_o <= '0;
        end else begin
            latch_o <= conv_end;
            if (conv_end) prox_data_o <= adc_in;
        end
    end

    assign state_o     = state;
    assign integ_win_o = (state == PS_CONVERT);
endmodule

// File: rtl/prox_cycle_seq_chk.sv
`timescale 1ns/1ps
module prox_cycle_seq_chk
    import prox_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_on,
    input logic              prox_en,
    input logic              wait_en,
    input logic              led_o,
    input logic [2:0]        state_o,
    input logic              latch_o,
    input logic [DATA_W-1:0] prox_data_o
);
    p_led_in_accum_r4: assert property (@(posedge clk) disable iff (rst)
        led_o |-> (state_o == PS_ACCUM));

    p_start_brief_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_START && pwr_on && (prox_en || wait_en)) |=> (state_o != PS_START));

    p_settle_first_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_CONVERT && $past(state_o) != PS_CONVERT)
        |-> ($past(state_o) == PS_SETTLE || $past(state_o) == PS_ACCUM));

    p_latch_after_conv_r6: assert property (@(posedge clk) disable iff (rst)
        latch_o |-> ($past(state_o) == PS_CONVERT && state_o != PS_CONVERT));

    p_latch_single_r6: assert property (@(posedge clk) disable iff (rst)
        latch_o |=> !latch_o);

    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !latch_o |-> $stable(prox_data_o));

    p_no_wait_when_off_r8: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_WAIT && $past(state_o) == PS_CONVERT) |-> $past(pwr_on));

    p_sleep_only_off_r9: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_SLEEP && $past(state_o) != PS_SLEEP) |-> !$past(pwr_on));

    p_wait_enabled_r7: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_WAIT && $past(state_o) != PS_WAIT) |-> $past(wait_en));
endmodule

bind prox_cycle_seq prox_cycle_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_on      (pwr_on),
    .prox_en     (prox_en),
    .wait_en     (wait_en),
    .led_o       (led_o),
    .state_o     (state_o),
    .latch_o     (latch_o),
    .prox_data_o (prox_data_o)
);

// File: tb/tb_prox_cycle_seq.sv
`timescale 1ns/1ps
module tb_prox_cycle_seq;
    localparam int STEP = 4;
    localparam int PT   = 2;
    localparam int DW   = 16;
    localparam int S_SLEEP = 0, S_START = 1, S_SETTLE = 2, S_ACCUM = 3, S_CONV = 4, S_WAIT = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          pwr_on = 1'b0, prox_en = 1'b0, wait_en = 1'b0, wait_long = 1'b0;
    logic [7:0]    pulse_cnt = '0, integ_time = 8'hFF, wait_time = 8'hFF;
    logic [DW-1:0] adc_in = '0;
    logic          led_o, integ_win_o, latch_o;
    logic [2:0]    state_o;
    logic [DW-1:0] prox_data_o;

    always #10 clk = ~clk;

    prox_cycle_seq #(.STEP_TICKS(STEP), .PULSE_TICKS(PT), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .tick(tick), .pwr_on(pwr_on), .prox_en(prox_en),
        .wait_en(wait_en), .wait_long(wait_long), .pulse_cnt(pulse_cnt),
        .integ_time(integ_time), .wait_time(wait_time), .adc_in(adc_in),
        .led_o(led_o), .integ_win_o(integ_win_o), .state_o(state_o),
        .latch_o(latch_o), .prox_data_o(prox_data_o)
    );

    int n_run = 0, n_fail = 0;
    int tick_period = 1;
    int q_st[$], q_tk[$], q_pl[$];
    int entries[6];
    int latches = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int st);
        case (st)
            S_START:  return "R2";
            S_SETTLE: return "R3";
            S_ACCUM:  return "R4";
            S_CONV:   return "R5";
            default:  return "R7";
        endcase
    endfunction

    task automatic push(input int st, input int tk, input int pl);
        q_st.push_back(st); q_tk.push_back(tk); q_pl.push_back(pl);
    endtask

    // tick generator: one tick every tick_period clocks, changed after the edge
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #2;
            if (ph >= tick_period - 1) begin tick = 1'b1; ph = 0; end
            else begin tick = 1'b0; ph++; end
        end
    end

    // monitor: per state visit counts ticks and LED pulses, compares with queue
    initial begin
        int cur = S_SLEEP, cnt = 0, pls = 0;
        bit led_prev = 0, win_bad = 0, exp_latch;
        foreach (entries[i]) entries[i] = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                exp_latch = 0;
                if (int'(state_o) != cur) begin
                    exp_latch = (cur == S_CONV);
                    if (cur != S_SLEEP) begin
                        if (q_st.size() == 0) begin
                            chk(0, "R2", "unexpected state visit", cur, -1);
                        end else begin
                            int e_st, e_tk, e_pl;
                            e_st = q_st.pop_front(); e_tk = q_tk.pop_front(); e_pl = q_pl.pop_front();
                            chk(cur == e_st, req_of(e_st), "visited state", cur, e_st);
                            if (e_tk >= 0) chk(cnt == e_tk, req_of(e_st), "ticks in state", cnt, e_tk);
                            if (e_st == S_ACCUM || pls != 0) chk(pls == e_pl, "R4", "LED pulses", pls, e_pl);
                            if (win_bad) chk(0, "R5", "window vs convert state", 1, 0);
                        end
                    end
                    if (exp_latch) begin
                        latches++;
                        chk(latch_o == 1'b1, "R6", "latch strobe after convert", latch_o, 1);
                        chk(prox_data_o == adc_in, "R6", "latched result", prox_data_o, adc_in);
                    end
                    cur = int'(state_o); cnt = 0; pls = 0; win_bad = 0;
                    if (cur < 6) entries[cur]++;
                end
                if (latch_o != exp_latch) chk(0, "R6", "stray latch strobe", latch_o, exp_latch);
                if (tick) cnt++;
                if (led_o && !led_prev) pls++;
                led_prev = led_o;
                if (integ_win_o != (state_o == 3'(S_CONV))) win_bad = 1;
            end
        end
    end

    task automatic run_scn(input bit pe, input bit we, input bit wl, input int pc, input int it,
                           input int wt, input int k_cyc, input int drop_st, input int tp, input int adc);
        int base, lat0;
        tick_period = tp;
        prox_en = pe; wait_en = we; wait_long = wl;
        pulse_cnt = 8'(pc); integ_time = 8'(it); wait_time = 8'(wt); adc_in = DW'(adc);
        for (int k = 1; k <= k_cyc; k++) begin
            push(S_START, -1, 0);
            push(S_SETTLE, STEP, 0);
            if (pc != 0) push(S_ACCUM, pc * PT, pc);
            push(S_CONV, (256 - it) * STEP, 0);
            if (k < k_cyc && we) push(S_WAIT, (256 - wt) * STEP * (wl ? 12 : 1), 0);
        end
        base = entries[drop_st]; lat0 = latches;
        @(negedge clk); #1; pwr_on = 1'b1;
        while (entries[drop_st] < base + k_cyc) begin @(negedge clk); #1; end
        pwr_on = 1'b0;
        while (state_o != 3'(S_SLEEP)) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        chk(q_st.size() == 0, "R8", "visits left after power-off", q_st.size(), 0);
        chk(latches - lat0 == k_cyc, "R8", "conversions completed", latches - lat0, k_cyc);
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(state_o == 3'(S_SLEEP), "R1", "state in reset", state_o, S_SLEEP);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(state_o == 3'(S_SLEEP), "R1", "state after reset", state_o, S_SLEEP);
        chk(!led_o && !integ_win_o && !latch_o, "R1", "outputs idle", {led_o, integ_win_o, latch_o}, 0);
        chk(prox_data_o == '0, "R1", "result cleared", prox_data_o, 0);

        // no phase enabled: start holds, then power-off leaves at once
        push(S_START, -1, 0);
        pwr_on = 1'b1;
        repeat (20) @(negedge clk); #1;
        chk(state_o == 3'(S_START), "R2", "start holds with no phase enabled", state_o, S_START);
        chk(led_o == 1'b0, "R4", "LED idle in start", led_o, 0);
        pwr_on = 1'b0;
        @(negedge clk); #1;
        chk(state_o == 3'(S_SLEEP), "R9", "sleep one edge after power-off in start", state_o, S_SLEEP);

        // proximity only, three cycles, dropped in convert
        run_scn(1, 0, 0, 3, 8'hFF, 8'hFF, 3, S_CONV, 1, 16'h0123);
        // zero pulses skips accumulate, wait enabled, slow tick, dropped in settle
        run_scn(1, 1, 0, 0, 8'hFE, 8'hFF, 2, S_SETTLE, 3, 16'h0456);
        // long wait, dropped in accumulate
        run_scn(1, 1, 1, 5, 8'hFD, 8'hFE, 2, S_ACCUM, 1, 16'h03FF);
        // maximum pulse, integration and wait counts
        run_scn(1, 1, 0, 255, 8'h00, 8'h00, 2, S_CONV, 1, 16'h0200);
        // wait_long with wait disabled has no wait phase
        run_scn(1, 0, 1, 1, 8'hFF, 8'h00, 2, S_CONV, 2, 16'h0077);

        // wait only (74 steps), power-off inside the second wait
        tick_period = 1; prox_en = 0; wait_en = 1; wait_long = 0; wait_time = 8'hB6;
        push(S_START, -1, 0); push(S_WAIT, 74 * STEP, 0);
        push(S_START, -1, 0); push(S_WAIT, -1, 0);
        base = entries[S_WAIT];
        pwr_on = 1'b1;
        while (entries[S_WAIT] < base + 2) begin @(negedge clk); #1; end
        pwr_on = 1'b0;
        @(negedge clk); #1;
        chk(state_o == 3'(S_SLEEP), "R9", "sleep one edge after power-off in wait", state_o, S_SLEEP);
        @(negedge clk); #1;
        chk(q_st.size() == 0, "R9", "visits left after wait abort", q_st.size(), 0);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule